// File: doc/BRIEF.md
# Double-Buffered Period PWM Channel

This block is a single pulse-width channel built around a 16-bit counter. Each counter step is gated by a clock enable picked from one of two kinds of source. The first kind is a set of eleven power-of-two taps of the master clock, from 1 up to 1024. The second kind is one of two linear dividers whose 8-bit values are set by software. The counter either climbs from zero to the end of the period and wraps (left-aligned), or climbs to the period value and then counts back to zero (center-aligned). In center-aligned mode each waveform cycle lasts twice as long.

Software never writes the active period directly. It writes an update port instead, and only the low 16 bits of that write are kept, in a shadow register. The channel copies the shadow into the active period only when the current period ends, so a waveform cycle is never cut short or stretched. Two protection flags, one from software and one from hardware, can each block the update port. A blocked write is dropped and raises a sticky violation flag, which stays set until a status read clears it. The output is high while the counter sits below the duty value, and it is held low whenever the active period is zero.

Top module: `pwm_period_chan`

## Requirements
- R1: After reset the counter, the active period, the output and the violation flag are all zero.
- R2: An accepted write stores bits 15:0 of the update data in the shadow, and bits 31:16 are discarded. The active period keeps its old value until the next period boundary.
- R3: In left-aligned mode (center_mode = 0) the counter steps 0, 1, ... P-1 and then wraps to 0, one step per clock enable. The wrap is the period boundary, so the output period is the division factor times P master clocks.
- R4: In center-aligned mode (center_mode = 1) the counter runs through 0 up to P and back down to 1, then returns to 0, which is the boundary. The counter never exceeds the active period. The output period is twice the division factor times P.
- R5: clk_sel values 0 to 10 give a clock enable every 2^clk_sel master clocks.
- R6: clk_sel = 11 uses divider A and clk_sel = 12 uses divider B, each dividing by its 8-bit value. A value of 1 passes every clock, and a value of 0 stops the counter. clk_sel values 13 to 15 also stop the counter.
- R7: pwm_out is high exactly when the active period is non-zero and the counter is below duty. With duty of 0 the output is always low, and with duty above the period it is always high.
- R8: A write while wp_sw or wp_hw is high leaves the shadow unchanged. A write while both are low is accepted.
- R9: A blocked write sets wp_err on the next clock. wp_err stays set until a cycle with sts_rd high clears it. When a blocked write and sts_rd arrive in the same cycle, wp_err stays set.
- R10: While the active period is zero the counter holds at 0 and every clock enable is a boundary, so the shadow is taken up on the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 4 | Counter clock source: 0-10 power-of-two tap, 11 divider A, 12 divider B, others off |
| div_a | input | 8 | Linear divider A value |
| div_b | input | 8 | Linear divider B value |
| center_mode | input | 1 | 0 left-aligned, 1 center-aligned |
| duty | input | 16 | Compare value for the output |
| upd_we | input | 1 | Period update write strobe |
| upd_data | input | 32 | Period update write data, low 16 bits used |
| wp_sw | input | 1 | Software write-protect flag |
| wp_hw | input | 1 | Hardware write-protect flag |
| sts_rd | input | 1 | Status read strobe, clears the violation flag |
| pwm_out | output | 1 | Waveform output |
| cnt_out | output | 16 | Current counter value |
| period_out | output | 16 | Active period value |
| wp_err | output | 1 | Sticky write-protect violation flag |

## Verification
Several rules are checked on every cycle: the active period changes only while the counter is at zero, the counter never goes past the active period, and a left-aligned step adds exactly one. The same per-cycle checks cover a stopped clock source freezing the counter, a zero period keeping the output low, a blocked write leaving the shadow alone, and the stickiness of the violation flag. Other behaviours can only be shown by the bench's scenarios. These include the exact rise-to-rise period and high time for each prescaler tap, for each divider and for both alignment modes, and the masking of the upper data bits. The scenarios also show that a period written in mid-cycle shows up only after the running cycle ends, and that a set request wins over a clear arriving in the same cycle.

// File: rtl/pwm_period_pkg.sv
package pwm_period_pkg;

    localparam int PWM_CNT_W    = 16;
    localparam int PWM_DIV_W    = 8;
    localparam int PWM_PRE_TAPS = 11;
    localparam int PWM_BUS_W    = 32;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } pwm_dir_e;

endpackage

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
    parameter int DIV_W = pwm_period_pkg::PWM_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (div_val == '0) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= div_val - DIV_W'(1)) begin
            tick     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_clk_sel.sv
module pwm_clk_sel #(
    parameter int PRE_TAPS = pwm_period_pkg::PWM_PRE_TAPS,
    parameter int DIV_W    = pwm_period_pkg::PWM_DIV_W,
    parameter int SEL_W    = $clog2(PRE_TAPS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DIV_W-1:0] div_b,
    output logic             tick
);

    localparam int PRE_W = (PRE_TAPS > 1) ? PRE_TAPS - 1 : 1;
    localparam logic [SEL_W-1:0] SEL_A = SEL_W'(PRE_TAPS);
    localparam logic [SEL_W-1:0] SEL_B = SEL_W'(PRE_TAPS + 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_TAPS-1:0] tap;
    logic [1:0]          lin_tick;
    logic [DIV_W-1:0]    lin_val [2];

    assign lin_val[0] = div_a;
    assign lin_val[1] = div_b;

    // Tap k fires once every 2^k clocks: when the low k bits of the free counter are all ones.
    for (genvar k = 0; k < PRE_TAPS; k++) begin : g_tap
        if (k == 0) begin : g_pass
            assign tap[k] = 1'b1;
        end else begin : g_div
            assign tap[k] = &st_q.pre[k-1:0];
        end
    end

    for (genvar d = 0; d < 2; d++) begin : g_lin
        pwm_lin_div #(
            .DIV_W(DIV_W)
        ) i_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .div_val(lin_val[d]),
            .tick   (lin_tick[d])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + PRE_W'(1);
        tick     = 1'b0;
        for (int k = 0; k < PRE_TAPS; k++) begin
            if (clk_sel == SEL_W'(k)) begin
                tick = tap[k];
            end
        end
        if (clk_sel == SEL_A) begin
            tick = lin_tick[0];
        end else if (clk_sel == SEL_B) begin
            tick = lin_tick[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_period_gate.sv
module pwm_period_gate #(
    parameter int CNT_W = pwm_period_pkg::PWM_CNT_W,
    parameter int BUS_W = pwm_period_pkg::PWM_BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_we,
    input  logic [BUS_W-1:0] upd_data,
    input  logic             wp_sw,
    input  logic             wp_hw,
    input  logic             sts_rd,
    output logic [CNT_W-1:0] shadow,
    output logic             wp_err
);

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic             err;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        blocked;
    logic        accepted;
    logic        unused_hi;

    assign unused_hi = ^upd_data[BUS_W-1:CNT_W];

    always_comb begin
        st_d     = st_q;
        blocked  = upd_we && (wp_sw || wp_hw);
        accepted = upd_we && !wp_sw && !wp_hw;
        if (accepted) begin
            st_d.shadow = upd_data[CNT_W-1:0];
        end
        // A new violation takes priority over a clearing status read.
        st_d.err = (st_q.err && !sts_rd) || blocked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow = st_q.shadow;
    assign wp_err = st_q.err;

endmodule

// File: rtl/pwm_wave_cnt.sv
module pwm_wave_cnt #(
    parameter int CNT_W = pwm_period_pkg::PWM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             center_mode,
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] shadow,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] period,
    output logic             pwm
);

    import pwm_period_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] prd;
        pwm_dir_e         dir;
    } wave_state_t;

    wave_state_t st_d, st_q;
    logic        boundary;

    always_comb begin
        st_d     = st_q;
        boundary = 1'b0;
        if (tick) begin
            if (st_q.prd == '0) begin
                boundary = 1'b1;
            end else if (!center_mode) begin
                st_d.dir = DIR_UP;
                if (st_q.cnt >= st_q.prd - CNT_W'(1)) begin
                    boundary = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end else if (st_q.dir == DIR_UP) begin
                if (st_q.cnt >= st_q.prd) begin
                    st_d.dir = DIR_DOWN;
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                    if (st_q.cnt + CNT_W'(1) == st_q.prd) begin
                        st_d.dir = DIR_DOWN;
                    end
                end
            end else begin
                if (st_q.cnt <= CNT_W'(1)) begin
                    boundary = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end
        if (boundary) begin
            st_d.cnt = '0;
            st_d.dir = DIR_UP;
            st_d.prd = shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, prd: '0, dir: DIR_UP};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign period = st_q.prd;
    assign pwm    = (st_q.prd != '0) && (st_q.cnt < duty);

endmodule

// File: rtl/pwm_period_chan.sv
module pwm_period_chan #(
    parameter int CNT_W    = pwm_period_pkg::PWM_CNT_W,
    parameter int DIV_W    = pwm_period_pkg::PWM_DIV_W,
    parameter int PRE_TAPS = pwm_period_pkg::PWM_PRE_TAPS,
    parameter int BUS_W    = pwm_period_pkg::PWM_BUS_W,
    localparam int SEL_W   = $clog2(PRE_TAPS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DIV_W-1:0] div_b,
    input  logic             center_mode,
    input  logic [CNT_W-1:0] duty,
    input  logic             upd_we,
    input  logic [BUS_W-1:0] upd_data,
    input  logic             wp_sw,
    input  logic             wp_hw,
    input  logic             sts_rd,
    output logic             pwm_out,
    output logic [CNT_W-1:0] cnt_out,
    output logic [CNT_W-1:0] period_out,
    output logic             wp_err
);

    logic             cnt_tick;
    logic [CNT_W-1:0] shadow_val;

    pwm_clk_sel #(
        .PRE_TAPS(PRE_TAPS),
        .DIV_W   (DIV_W),
        .SEL_W   (SEL_W)
    ) i_clk_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_sel(clk_sel),
        .div_a  (div_a),
        .div_b  (div_b),
        .tick   (cnt_tick)
    );

    pwm_period_gate #(
        .CNT_W(CNT_W),
        .BUS_W(BUS_W)
    ) i_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_we  (upd_we),
        .upd_data(upd_data),
        .wp_sw   (wp_sw),
        .wp_hw   (wp_hw),
        .sts_rd  (sts_rd),
        .shadow  (shadow_val),
        .wp_err  (wp_err)
    );

    pwm_wave_cnt #(
        .CNT_W(CNT_W)
    ) i_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (cnt_tick),
        .center_mode(center_mode),
        .duty       (duty),
        .shadow     (shadow_val),
        .cnt        (cnt_out),
        .period     (period_out),
        .pwm        (pwm_out)
    );

endmodule

// File: rtl/pwm_period_chan_chk.sv
module pwm_period_chan_chk #(
    parameter int CNT_W    = 16,
    parameter int DIV_W    = 8,
    parameter int PRE_TAPS = 11,
    parameter int SEL_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] clk_sel,
    input logic [DIV_W-1:0] div_a,
    input logic             center_mode,
    input logic             upd_we,
    input logic             wp_sw,
    input logic             wp_hw,
    input logic             sts_rd,
    input logic             cnt_tick,
    input logic [CNT_W-1:0] shadow_val,
    input logic             pwm_out,
    input logic [CNT_W-1:0] cnt_out,
    input logic [CNT_W-1:0] period_out,
    input logic             wp_err
);

    localparam logic [SEL_W-1:0] SEL_A = SEL_W'(PRE_TAPS);
    localparam logic [SEL_W-1:0] SEL_B = SEL_W'(PRE_TAPS + 1);

    a_r2_period_change_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(period_out) |-> cnt_out == '0);

    a_r3_left_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!center_mode && cnt_tick && period_out != '0 && (cnt_out + CNT_W'(1)) < period_out)
        |=> cnt_out == $past(cnt_out) + CNT_W'(1));

    a_r4_cnt_le_period: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_out <= period_out);

    a_r6_clock_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_sel == SEL_A && div_a == '0) || clk_sel > SEL_B)
        |=> $stable(cnt_out) && $stable(period_out));

    a_r7_zero_period_low: assert property (@(posedge clk) disable iff (!rst_n)
        period_out == '0 |-> !pwm_out);

    a_r8_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_we && (wp_sw || wp_hw)) |=> $stable(shadow_val));

    a_r9_violation_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_we && (wp_sw || wp_hw)) |=> wp_err);

    a_r9_violation_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_err && !sts_rd) |=> wp_err);

endmodule

bind pwm_period_chan pwm_period_chan_chk #(
    .CNT_W   (CNT_W),
    .DIV_W   (DIV_W),
    .PRE_TAPS(PRE_TAPS),
    .SEL_W   (SEL_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .div_a      (div_a),
    .center_mode(center_mode),
    .upd_we     (upd_we),
    .wp_sw      (wp_sw),
    .wp_hw      (wp_hw),
    .sts_rd     (sts_rd),
    .cnt_tick   (cnt_tick),
    .shadow_val (shadow_val),
    .pwm_out    (pwm_out),
    .cnt_out    (cnt_out),
    .period_out (period_out),
    .wp_err     (wp_err)
);

// File: tb/test_pwm_period_chan.sv
`timescale 1ns/1ps
module test_pwm_period_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  clk_sel = '0;
    logic [7:0]  div_a = '0;
    logic [7:0]  div_b = '0;
    logic        center_mode = 1'b0;
    logic [15:0] duty = '0;
    logic        upd_we = 1'b0;
    logic [31:0] upd_data = '0;
    logic        wp_sw = 1'b0;
    logic        wp_hw = 1'b0;
    logic        sts_rd = 1'b0;
    logic        pwm_out;
    logic [15:0] cnt_out;
    logic [15:0] period_out;
    logic        wp_err;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        bit    wave;
        string tag;
        int    cnt;
        int    prd;
        int    out;
        int    err;
        int    per;
        int    hi;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;

    pwm_period_chan i_pwm_period_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_sel    (clk_sel),
        .div_a      (div_a),
        .div_b      (div_b),
        .center_mode(center_mode),
        .duty       (duty),
        .upd_we     (upd_we),
        .upd_data   (upd_data),
        .wp_sw      (wp_sw),
        .wp_hw      (wp_hw),
        .sts_rd     (sts_rd),
        .pwm_out    (pwm_out),
        .cnt_out    (cnt_out),
        .period_out (period_out),
        .wp_err     (wp_err)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [31:0] data);
        upd_we   = 1'b1;
        upd_data = data;
        step(1);
        upd_we   = 1'b0;
    endtask

    // Expected state at the next falling edge; -1 means not compared.
    task automatic exp_state(string tag, int c, int p, int o, int e);
        item_t it;
        it.wave = 1'b0; it.tag = tag; it.cnt = c; it.prd = p; it.out = o; it.err = e;
        it.per = 0; it.hi = 0;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic exp_wave(string tag, int per, int hi);
        item_t it;
        it.wave = 1'b1; it.tag = tag; it.cnt = -1; it.prd = -1; it.out = -1; it.err = -1;
        it.per = per; it.hi = hi;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    // Monitor: pops expected items and compares them with what the outputs show.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q[0];
                if (!it.wave) begin
                    if (it.cnt >= 0) check({it.tag, " cnt"}, int'(cnt_out), it.cnt);
                    if (it.prd >= 0) check({it.tag, " period"}, int'(period_out), it.prd);
                    if (it.out >= 0) check({it.tag, " out"}, int'(pwm_out), it.out);
                    if (it.err >= 0) check({it.tag, " wp_err"}, int'(wp_err), it.err);
                end else begin
                    logic pv;
                    int per;
                    int hi;
                    pv = pwm_out;
                    @(negedge clk);
                    while (!(!pv && pwm_out)) begin
                        pv = pwm_out;
                        @(negedge clk);
                    end
                    per = 1; hi = 1; pv = 1'b1;
                    @(negedge clk);
                    while (!(!pv && pwm_out)) begin
                        per++;
                        if (pwm_out) hi++;
                        pv = pwm_out;
                        @(negedge clk);
                    end
                    check({it.tag, " period clocks"}, per, it.per);
                    check({it.tag, " high clocks"}, hi, it.hi);
                end
                void'(sb_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int c0;
        int p0;
        step(3);
        rst_n = 1'b1;
        exp_state("R1 reset state", 0, 0, 0, 0);

        // Zero period: the shadow is taken up on the next enable; upper data bits dropped.
        duty = 16'd2;
        wr(32'h1234_0005);
        exp_state("R2 shadow not yet active", -1, 0, -1, -1);
        step(1);
        exp_state("R10 load on zero period, R2 low bits only", 0, 5, -1, -1);

        exp_wave("R3 left aligned undivided", 5, 2);
        clk_sel = 4'd2;
        step(30);
        exp_wave("R5 tap divide by 4", 20, 8);

        // Mid-period write waits for the boundary.
        wr(32'd8);
        exp_state("R2 active held mid period", -1, 5, -1, -1);
        step(25);
        exp_state("R2 applied at boundary", -1, 8, -1, -1);

        wr(32'd2);
        step(40);
        clk_sel = 4'd10;
        duty = 16'd1;
        exp_wave("R5 tap divide by 1024", 2048, 1024);

        clk_sel = 4'd0;
        wr(32'd4);
        step(10);
        clk_sel = 4'd11;
        div_a = 8'd3;
        exp_wave("R6 divider A by 3", 12, 3);
        clk_sel = 4'd12;
        div_b = 8'd1;
        exp_wave("R6 divider B pass through", 4, 1);

        clk_sel = 4'd11;
        div_a = 8'd0;
        step(2);
        c0 = int'(cnt_out);
        p0 = int'(period_out);
        step(50);
        exp_state("R6 divider zero stops", c0, p0, -1, -1);
        clk_sel = 4'd13;
        div_a = 8'd3;
        step(2);
        c0 = int'(cnt_out);
        step(50);
        exp_state("R6 unused select stops", c0, p0, -1, -1);

        clk_sel = 4'd0;
        center_mode = 1'b1;
        duty = 16'd2;
        exp_wave("R4 center aligned undivided", 8, 3);
        clk_sel = 4'd11;
        div_a = 8'd2;
        exp_wave("R4 center aligned divider A by 2", 16, 6);

        clk_sel = 4'd0;
        center_mode = 1'b0;
        step(20);
        duty = 16'd5;
        step(3);
        exp_state("R7 duty above period high", -1, 4, 1, -1);
        step(2);
        exp_state("R7 duty above period still high", -1, 4, 1, -1);
        duty = 16'd0;
        exp_state("R7 zero duty low", -1, 4, 0, -1);

        duty = 16'd5;
        wr(32'd0);
        step(10);
        exp_state("R10 zero period holds low", 0, 0, 0, 0);

        wp_sw = 1'b1;
        wr(32'd7);
        exp_state("R9 violation sets flag", -1, -1, -1, 1);
        step(10);
        exp_state("R8 software protect drops write", 0, 0, 0, 1);
        sts_rd = 1'b1;
        step(1);
        sts_rd = 1'b0;
        exp_state("R9 status read clears", -1, -1, -1, 0);

        wp_sw = 1'b0;
        wp_hw = 1'b1;
        wr(32'd9);
        step(10);
        exp_state("R8 hardware protect drops write", 0, 0, -1, 1);
        sts_rd = 1'b1;
        upd_we = 1'b1;
        upd_data = 32'd9;
        step(1);
        sts_rd = 1'b0;
        upd_we = 1'b0;
        exp_state("R9 set beats clear", -1, 0, -1, 1);
        wp_hw = 1'b0;
        sts_rd = 1'b1;
        step(1);
        sts_rd = 1'b0;
        exp_state("R9 cleared after protect off", -1, -1, -1, 0);

        wr(32'hFFFF_0003);
        step(3);
        exp_state("R8 unprotected write accepted", -1, 3, -1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule